// File: doc/BRIEF.md
# Level-Triggered Interrupt Presentation Controller

This block gathers a configurable number of level-sensitive hardware interrupt lines and presents them to a single processor. Each line has a fixed source number, which is a base value plus the line's index. All lines share one fixed source priority. The processor holds a current-priority value, and an interrupt is delivered only when the shared source priority is numerically lower than that value. Lower numbers are more favoured.

The processor reaches the block through a small word-addressed register window. Reading the accept register claims the lowest-numbered active line. The read returns that line's source number together with the previous current priority, and it raises the current priority to the source priority, which masks further delivery. Writing the accept register signals end of interrupt and loads a new current priority from the written word. A line that is still held high is then presented again. A separate priority register lets software read and set the current priority directly.

Top module: `ilp_ctrl`

## Requirements
- R1: After reset, `irq_o` is 0, `bus_ack_o` is 0 and the current priority is 0, so every line is masked.
- R2: `irq_o` rises on the clock edge after which some line is high and `SRC_PRIO` (default 8'h80) is numerically below the current priority. It falls on the edge after which no line is high.
- R3: When the current priority is less than or equal to `SRC_PRIO`, `irq_o` stays 0 whatever the lines do.
- R4: The priority register at word address 1 holds the current priority in bits 7:0. A write to it loads wdata[7:0], and a read returns it with bits 31:8 zero.
- R5: A read of the accept register at word address 0, made while an interrupt is presentable, returns the previous current priority in bits 31:24 and the source number (SRC_BASE + line index, default base 16) in bits 23:0. The same read sets the current priority to `SRC_PRIO`, so `irq_o` is 0 after that edge.
- R6: A read of the accept register while nothing is presentable returns source number 0 and leaves the current priority unchanged.
- R7: A write to the accept register is end of interrupt. It loads the current priority from wdata[31:24], and a line that is still high raises `irq_o` again on that same edge.
- R8: When several lines are high, the lowest line index is the one reported.
- R9: `bus_ack_o` is high for exactly the cycle after a one-cycle `bus_req_i`, and `bus_rdata_o` is valid in that cycle. Word addresses 2 and 3 read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines_i | input | NUM_SRC | Level-sensitive interrupt lines, index = line number |
| bus_req_i | input | 1 | Register access request, one cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | Word address: 0 accept, 1 priority |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid while ack is high |
| bus_ack_o | output | 1 | Access acknowledge, one cycle after request |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
Every result of the block is registered, so each one appears exactly one edge after the stimulus that causes it. A change on the lines shows on `irq_o` after one edge. A bus request gives `bus_ack_o` and `bus_rdata_o`, and any change to the priority, one edge later. The bench drives inputs on falling edges and samples on the next falling edge after the edge that takes the stimulus. This means each read-data, acknowledge and interrupt check falls in the first cycle where the value is due, and a result that comes late or early is caught.

// File: rtl/ilp_pkg.sv
package ilp_pkg;
  localparam int BUS_AW = 2;
  localparam int BUS_DW = 32;
  localparam int PRIO_W = 8;

  typedef enum logic [BUS_AW-1:0] {
    REG_ACCEPT = 2'd0,
    REG_PRIO   = 2'd1
  } reg_sel_e;
endpackage

// File: rtl/ilp_pick.sv
module ilp_pick #(
  parameter int NUM_SRC = 16,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] lines_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   idx_o
);
  logic [NUM_SRC:0]   seen;
  logic [NUM_SRC-1:0] grant;

  assign seen[0] = 1'b0;
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_chain
    assign seen[g+1] = seen[g] | lines_i[g];
    assign grant[g]  = lines_i[g] & ~seen[g];
  end

  assign any_o = seen[NUM_SRC];

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (grant[i]) idx_o = idx_o | IDX_W'(i);
    end
  end
endmodule

// File: rtl/ilp_cppr.sv
module ilp_cppr
  import ilp_pkg::*;
#(
  parameter logic [PRIO_W-1:0] SRC_PRIO = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              any_i,
  input  logic              take_i,
  input  logic              load_i,
  input  logic [PRIO_W-1:0] load_val_i,
  output logic [PRIO_W-1:0] cur_prio_o,
  output logic              present_o,
  output logic              irq_o
);
  logic [PRIO_W-1:0] prio_q, prio_d;
  logic              irq_q, irq_d;

  assign present_o  = any_i && (SRC_PRIO < prio_q);
  assign cur_prio_o = prio_q;
  assign irq_o      = irq_q;

  always_comb begin
    prio_d = prio_q;
    if (load_i)      prio_d = load_val_i;
    else if (take_i) prio_d = SRC_PRIO;
    irq_d = any_i && (SRC_PRIO < prio_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      prio_q <= prio_d;
      irq_q  <= irq_d;
    end
  end

  AST_TAKE_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(take_i && !load_i) |-> (prio_q == SRC_PRIO) && !irq_q); // R5
  AST_LOAD_APPLIES: assert property (@(posedge clk) disable iff (!rst_n)
    $past(load_i) |-> prio_q == $past(load_val_i)); // R7
  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!load_i && prio_q <= SRC_PRIO) |-> !irq_q); // R3
  AST_IRQ_NEEDS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(any_i)); // R2
endmodule

// File: rtl/ilp_ctrl.sv
module ilp_ctrl
  import ilp_pkg::*;
#(
  parameter int                NUM_SRC  = 16,
  parameter int                SRC_BASE = 16,
  parameter logic [PRIO_W-1:0] SRC_PRIO = 8'h80
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_lines_i,
  input  logic               bus_req_i,
  input  logic               bus_we_i,
  input  logic [1:0]         bus_addr_i,
  input  logic [31:0]        bus_wdata_i,
  output logic [31:0]        bus_rdata_o,
  output logic               bus_ack_o,
  output logic               irq_o
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int SRC_W = $clog2(SRC_BASE + NUM_SRC);
  localparam int PAD_W = 24 - SRC_W;

  logic              any_act;
  logic [IDX_W-1:0]  win_idx;
  logic [SRC_W-1:0]  win_src;
  logic [PRIO_W-1:0] cur_prio;
  logic              present;
  logic              rd_acc, wr_acc, rd_pri, wr_pri;
  logic              take, load;
  logic [PRIO_W-1:0] load_val;
  logic [31:0]       rdata_d, rdata_q;
  logic              ack_q;

  ilp_pick #(.NUM_SRC(NUM_SRC)) u_pick (
    .lines_i (irq_lines_i),
    .any_o   (any_act),
    .idx_o   (win_idx)
  );

  assign win_src = SRC_W'(SRC_BASE) + SRC_W'(win_idx);

  assign rd_acc = bus_req_i && !bus_we_i && (bus_addr_i == REG_ACCEPT);
  assign wr_acc = bus_req_i &&  bus_we_i && (bus_addr_i == REG_ACCEPT);
  assign rd_pri = bus_req_i && !bus_we_i && (bus_addr_i == REG_PRIO);
  assign wr_pri = bus_req_i &&  bus_we_i && (bus_addr_i == REG_PRIO);

  assign take     = rd_acc && present;
  assign load     = wr_acc || wr_pri;
  assign load_val = wr_acc ? bus_wdata_i[31:24] : bus_wdata_i[PRIO_W-1:0];

  ilp_cppr #(.SRC_PRIO(SRC_PRIO)) u_cppr (
    .clk        (clk),
    .rst_n      (rst_n),
    .any_i      (any_act),
    .take_i     (take),
    .load_i     (load),
    .load_val_i (load_val),
    .cur_prio_o (cur_prio),
    .present_o  (present),
    .irq_o      (irq_o)
  );

  always_comb begin
    rdata_d = '0;
    if (rd_acc) begin
      rdata_d[31:24] = cur_prio;
      if (present) rdata_d[23:0] = {{PAD_W{1'b0}}, win_src};
    end else if (rd_pri) begin
      rdata_d[PRIO_W-1:0] = cur_prio;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ack_q <= bus_req_i;
      if (bus_req_i) rdata_q <= rdata_d;
    end
  end

  assign bus_ack_o   = ack_q;
  assign bus_rdata_o = rdata_q;

  AST_ACK_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack_o == $past(bus_req_i)); // R9
  AST_WINNER_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    any_act |-> irq_lines_i[win_idx]); // R8
  AST_WINNER_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    any_act |-> ((irq_lines_i & ((NUM_SRC'(1) << win_idx) - NUM_SRC'(1))) == '0)); // R8
  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_acc && !present) |-> bus_rdata_o[23:0] == 24'd0); // R6
endmodule

// File: tb/sim_ilp_ctrl.sv
`timescale 1ns/1ps
module sim_ilp_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] lines = '0;
  logic        req = 1'b0, we = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ack, irq;
  int          n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  ilp_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .irq_lines_i(lines),
    .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .bus_ack_o(ack), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one access; on return it is the ack cycle
  task automatic access(input logic w, input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    chk("R9 ack", 32'(ack), 32'd1);
  endtask

  task automatic set_lines(input logic [15:0] v);
    @(negedge clk);
    lines = v;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 irq", 32'(irq), 0);
    chk("R1 ack", 32'(ack), 0);
    access(1'b0, 2'd1, 0);
    chk("R1 prio", rdata, 32'h0);
  endtask

  task automatic t_masked;
    set_lines(16'h0001);
    chk("R3 prio0 masked", 32'(irq), 0);
    access(1'b1, 2'd1, 32'h80);
    chk("R3 prio equal masked", 32'(irq), 0);
    set_lines(16'h0000);
  endtask

  task automatic t_present;
    access(1'b1, 2'd1, 32'hFFFF_FFF0);
    access(1'b0, 2'd1, 0);
    chk("R4 prio readback", rdata, 32'h0000_00F0);
    chk("R2 idle", 32'(irq), 0);
    set_lines(16'h0100);
    chk("R2 rise", 32'(irq), 1);
    set_lines(16'h0000);
    chk("R2 fall", 32'(irq), 0);
  endtask

  task automatic t_accept;
    set_lines(16'h0A40);
    access(1'b0, 2'd0, 0);
    chk("R5 R8 accept data", rdata, {8'hF0, 24'd22});
    chk("R5 irq dropped", 32'(irq), 0);
    access(1'b0, 2'd1, 0);
    chk("R5 prio raised", rdata, 32'h80);
    access(1'b0, 2'd0, 0);
    chk("R6 masked read", rdata, {8'h80, 24'd0});
    access(1'b0, 2'd1, 0);
    chk("R6 prio kept", rdata, 32'h80);
    access(1'b1, 2'd0, 32'hFF00_0000);
    chk("R7 re-present", 32'(irq), 1);
    access(1'b0, 2'd1, 0);
    chk("R7 prio restored", rdata, 32'hFF);
    set_lines(16'h8000);
    access(1'b0, 2'd0, 0);
    chk("R8 top line", rdata, {8'hFF, 24'd31});
    set_lines(16'h0000);
    access(1'b1, 2'd0, 32'hFF00_0000);
    chk("R7 eoi no line", 32'(irq), 0);
    access(1'b0, 2'd0, 0);
    chk("R6 empty read", rdata, {8'hFF, 24'd0});
    set_lines(16'hFFFF);
    access(1'b0, 2'd0, 0);
    chk("R8 all lines", rdata, {8'hFF, 24'd16});
    access(1'b1, 2'd0, 32'hC000_0000);
    set_lines(16'h0000);
  endtask

  task automatic t_unmapped;
    access(1'b1, 2'd2, 32'h0000_0000);
    access(1'b1, 2'd3, 32'h0000_0000);
    access(1'b0, 2'd1, 0);
    chk("R9 writes ignored", rdata, 32'hC0);
    access(1'b0, 2'd2, 0);
    chk("R9 unmapped read", rdata, 0);
    @(negedge clk);
    chk("R9 ack single", 32'(ack), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_masked();
    t_present();
    t_accept();
    t_unmapped();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule